// File: doc/BRIEF.md
# Multicore Private Peripheral Window Front End

This block sits in front of an 8 KB private peripheral window that is shared by up to four cores. It receives single accesses on a simple register bus. Each access has a request strobe, a write enable, an address, write data and a sideband carrying the ID of the requesting core. The lowest 256 bytes hold a small set of snoop-control registers, and the block implements these itself. The rest of the window is decoded into one-hot select strobes for external slots:

- the interrupt CPU-interface pages;
- the timer and watchdog pages;
- the interrupt distributor.

The block passes each slot its local offset, the write data and a core number. It then returns the read data of whichever slot was selected.

The CPU-interface, timer and watchdog regions each start with a "current core" alias slot, followed by one slot per core. When an access hits an alias slot, the block forwards the ID of the requesting core. When it hits a per-core slot, the block forwards that slot's fixed core number. Every access gets a registered response in the next cycle.

Separately, the block spreads each core's timer and watchdog interrupt lines onto that core's 32-line private interrupt bank.

Top module: `cpw_front`

## Requirements
- R1: The control register sits at offset 0x00 and resets to zero. A write to it stores only write-data bit 0, and a read returns that bit in bit 0 with every other bit zero.
- R2: A read of offset 0x04 returns the configuration word. Bits [1:0] hold NUM_CORES-1, bits [4+NUM_CORES-1:4] are all ones, and every other bit is zero. With 4 cores the word is 0x000000F3, and with 2 cores it is 0x00000031.
- R3: Reads of offsets 0x08 and 0x0C return zero without an error. A write to 0x0C completes without an error and leaves the control register unchanged.
- R4: Any other access inside 0x000–0x0FF sets `bus_err` for exactly the one response cycle and returns zero data. This covers reads of offsets other than exactly 0x00, 0x04, 0x08 and 0x0C, and writes to offsets other than exactly 0x00 and 0x0C. Such an access does not change the control register.
- R5: Addresses 0x100 + s*0x100 through 0x1FF + s*0x100, for s = 0..NUM_CORES, select `cpuif_sel[s]`, and `slot_off` carries address bits [7:0].
- R6: For s = 0..NUM_CORES, bytes 0x00–0x1F of page 0x600 + s*0x100 select `tmr_sel[s]`, and bytes 0x20–0x3F of the same page select `wdt_sel[s]`. In both cases `slot_off` carries address bits [4:0].
- R7: Addresses 0x1000–0x1FFF select `dist_sel`, and `slot_off` carries address bits [11:0].
- R8: An address in a slot numbered above NUM_CORES, in bytes 0x40–0xFF of a timer page, or in pages 0xB00–0xFFF when those lie beyond the last slot, raises no select. It responds like an R4 error: `bus_err` is set and the data is zero.
- R9: `ppi_irq[c*32+29]` follows `tmr_irq[c]` and `ppi_irq[c*32+30]` follows `wdt_irq[c]` with no delay. Every other `ppi_irq` bit is zero.
- R10: While a slot-0 (alias) select is high, `slot_core` equals `bus_core`. For slot s>0, `slot_core` is s-1. With no CPU-interface, timer or watchdog select high, `slot_core` is zero.
- R11: Select strobes are high only in a cycle with `bus_req` high. `slot_we` is high only when a select is high and `bus_we` is set. `bus_ready` is high exactly in the cycle after each request, and low otherwise. All response outputs are zero in reset.
- R12: A read response carries the selected slot's read data as sampled in the request cycle. Write responses, error responses and idle cycles carry zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request strobe |
| bus_we | input | 1 | Write enable |
| bus_addr | input | 13 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_core | input | 2 | ID of the requesting core |
| bus_rdata | output | 32 | Registered read data |
| bus_ready | output | 1 | Response valid, one cycle after the request |
| bus_err | output | 1 | Bad-access flag for the response cycle |
| cpuif_sel | output | NUM_CORES+1 | CPU-interface slot selects (slot 0 is the alias) |
| tmr_sel | output | NUM_CORES+1 | Timer slot selects |
| wdt_sel | output | NUM_CORES+1 | Watchdog slot selects |
| dist_sel | output | 1 | Distributor select |
| slot_we | output | 1 | Write strobe to the selected slot |
| slot_wdata | output | 32 | Write data to the slots |
| slot_off | output | 12 | Offset inside the selected slot |
| slot_core | output | 2 | Core number for the selected slot |
| cpuif_rdata | input | 32*(NUM_CORES+1) | CPU-interface slot read data |
| tmr_rdata | input | 32*(NUM_CORES+1) | Timer slot read data |
| wdt_rdata | input | 32*(NUM_CORES+1) | Watchdog slot read data |
| dist_rdata | input | 32 | Distributor read data |
| tmr_irq | input | NUM_CORES | Per-core timer interrupt |
| wdt_irq | input | NUM_CORES | Per-core watchdog interrupt |
| ppi_irq | output | 32*NUM_CORES | Per-core private interrupt banks |

## Verification
The bench builds two copies of the block side by side: one with NUM_CORES=4 and one with NUM_CORES=2. Both copies see the same stimulus. The 4-core copy reaches every slot, including the last CPU-interface page at 0x500. The 2-core copy turns slots 3 and 4 of each region into unmapped space, which exercises the beyond-count error path. It also produces a second configuration word, so the core-count encoding is tested at two values.

// File: rtl/cpw_pkg.sv
package cpw_pkg;

  // Window geometry
  localparam int ADDR_W     = 13;
  localparam int DATA_W     = 32;
  localparam int OFF_W      = 12;
  localparam int CID_W      = 2;
  localparam int IDX_W      = 4;
  localparam int BANK_W     = 32;

  // Page numbers (address bits [11:8]) where each slot row starts
  localparam int CPUIF_PAGE0 = 1;
  localparam int TMR_PAGE0   = 6;

  // Byte limits inside a timer page
  localparam logic [7:0] TMR_END = 8'h20;
  localparam logic [7:0] WDT_END = 8'h40;

  // Snoop-control register offsets
  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_CFG   = 8'h04;
  localparam logic [7:0] OFF_STAT  = 8'h08;
  localparam logic [7:0] OFF_INVAL = 8'h0C;

  // Private interrupt positions inside a bank
  localparam int TMR_PPI = 29;
  localparam int WDT_PPI = 30;

  typedef enum logic [2:0] {
    RG_SCU,
    RG_CPUIF,
    RG_TMR,
    RG_WDT,
    RG_DIST,
    RG_NONE
  } region_e;

endpackage

// File: rtl/cpw_addr_map.sv
module cpw_addr_map
  import cpw_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  slot_idx,
  output logic [OFF_W-1:0]  local_off
);

  localparam int LAST_SLOT = NUM_CORES;

  logic [3:0] page;
  logic [7:0] byte_off;
  int         row;

  always_comb begin
    page      = addr[11:8];
    byte_off  = addr[7:0];
    region    = RG_NONE;
    slot_idx  = '0;
    local_off = '0;
    row       = 0;
    if (addr[ADDR_W-1]) begin
      region    = RG_DIST;
      local_off = addr[OFF_W-1:0];
    end else if (page == 4'd0) begin
      region    = RG_SCU;
      local_off = {4'b0, byte_off};
    end else if (int'(page) < TMR_PAGE0) begin
      row = int'(page) - CPUIF_PAGE0;
      if (row <= LAST_SLOT) begin
        region    = RG_CPUIF;
        slot_idx  = IDX_W'(row);
        local_off = {4'b0, byte_off};
      end
    end else begin
      row = int'(page) - TMR_PAGE0;
      if (row <= LAST_SLOT) begin
        if (byte_off < TMR_END) begin
          region    = RG_TMR;
          slot_idx  = IDX_W'(row);
          local_off = {7'b0, byte_off[4:0]};
        end else if (byte_off < WDT_END) begin
          region    = RG_WDT;
          slot_idx  = IDX_W'(row);
          local_off = {7'b0, byte_off[4:0]};
        end
      end
    end
  end

endmodule

// File: rtl/cpw_scu_regs.sv
module cpw_scu_regs
  import cpw_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic              we,
  input  logic [7:0]        off,
  input  logic              wbit,
  output logic [DATA_W-1:0] rd_word,
  output logic              bad
);

  localparam int MASK_LSB = 4;

  logic              ctrl_q;
  logic              ctrl_d;
  logic              ctrl_en;
  logic [DATA_W-1:0] cfg_word;
  logic              off_ok;

  // Configuration word derived from the core count
  always_comb begin
    cfg_word                      = '0;
    cfg_word[CID_W-1:0]           = CID_W'(NUM_CORES - 1);
    cfg_word[MASK_LSB +: NUM_CORES] = '1;
  end

  // Next state of the control bit
  always_comb begin
    ctrl_en = acc && we && (off == OFF_CTRL);
    ctrl_d  = ctrl_en ? wbit : ctrl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= 1'b0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  // Offset legality and read mux
  always_comb begin
    if (we) off_ok = (off == OFF_CTRL) || (off == OFF_INVAL);
    else    off_ok = (off == OFF_CTRL) || (off == OFF_CFG) ||
                     (off == OFF_STAT) || (off == OFF_INVAL);
    bad = acc && !off_ok;
    case (off)
      OFF_CTRL: rd_word = {{(DATA_W-1){1'b0}}, ctrl_q};
      OFF_CFG:  rd_word = cfg_word;
      default:  rd_word = '0;
    endcase
  end

  // R1: a control write keeps write-data bit 0
  a_r1_ctrl_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && we && off == OFF_CTRL) |=> (ctrl_q == $past(wbit)));

  // R3/R4: writes anywhere but offset 0 leave the control bit alone
  a_r4_ctrl_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && we && off != OFF_CTRL) |=> $stable(ctrl_q));

endmodule

// File: rtl/cpw_irq_route.sv
module cpw_irq_route
  import cpw_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic [NUM_CORES-1:0]        tmr_irq,
  input  logic [NUM_CORES-1:0]        wdt_irq,
  output logic [NUM_CORES*BANK_W-1:0] ppi_irq
);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [BANK_W-1:0] bank;
    always_comb begin
      bank          = '0;
      bank[TMR_PPI] = tmr_irq[c];
      bank[WDT_PPI] = wdt_irq[c];
    end
    assign ppi_irq[c*BANK_W +: BANK_W] = bank;
  end

endmodule

// File: rtl/cpw_front.sv
module cpw_front
  import cpw_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               bus_req,
  input  logic                               bus_we,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic [DATA_W-1:0]                  bus_wdata,
  input  logic [CID_W-1:0]                   bus_core,
  output logic [DATA_W-1:0]                  bus_rdata,
  output logic                               bus_ready,
  output logic                               bus_err,
  output logic [NUM_CORES:0]                 cpuif_sel,
  output logic [NUM_CORES:0]                 tmr_sel,
  output logic [NUM_CORES:0]                 wdt_sel,
  output logic                               dist_sel,
  output logic                               slot_we,
  output logic [DATA_W-1:0]                  slot_wdata,
  output logic [OFF_W-1:0]                   slot_off,
  output logic [CID_W-1:0]                   slot_core,
  input  logic [(NUM_CORES+1)*DATA_W-1:0]    cpuif_rdata,
  input  logic [(NUM_CORES+1)*DATA_W-1:0]    tmr_rdata,
  input  logic [(NUM_CORES+1)*DATA_W-1:0]    wdt_rdata,
  input  logic [DATA_W-1:0]                  dist_rdata,
  input  logic [NUM_CORES-1:0]               tmr_irq,
  input  logic [NUM_CORES-1:0]               wdt_irq,
  output logic [NUM_CORES*BANK_W-1:0]        ppi_irq
);

  localparam int NSLOT = NUM_CORES + 1;

  region_e           region;
  logic [IDX_W-1:0]  slot_idx;
  logic [OFF_W-1:0]  local_off;
  logic [DATA_W-1:0] scu_rd;
  logic              scu_bad;
  logic              scu_acc;
  logic              any_core_sel;
  logic              any_sel;
  logic [DATA_W-1:0] slot_rd;
  logic [DATA_W-1:0] rd_mux;

  logic              rsp_en;
  logic              ready_d, ready_q;
  logic              err_d, err_q;
  logic [DATA_W-1:0] data_d, data_q;

  cpw_addr_map #(.NUM_CORES(NUM_CORES)) u_map (
    .addr      (bus_addr),
    .region    (region),
    .slot_idx  (slot_idx),
    .local_off (local_off)
  );

  assign scu_acc = bus_req && (region == RG_SCU);

  cpw_scu_regs #(.NUM_CORES(NUM_CORES)) u_scu (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc     (scu_acc),
    .we      (bus_we),
    .off     (local_off[7:0]),
    .wbit    (bus_wdata[0]),
    .rd_word (scu_rd),
    .bad     (scu_bad)
  );

  cpw_irq_route #(.NUM_CORES(NUM_CORES)) u_irq (
    .tmr_irq (tmr_irq),
    .wdt_irq (wdt_irq),
    .ppi_irq (ppi_irq)
  );

  // Per-slot select strobes
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign cpuif_sel[s] = bus_req && (region == RG_CPUIF) && (slot_idx == IDX_W'(s));
    assign tmr_sel[s]   = bus_req && (region == RG_TMR)   && (slot_idx == IDX_W'(s));
    assign wdt_sel[s]   = bus_req && (region == RG_WDT)   && (slot_idx == IDX_W'(s));
  end
  assign dist_sel = bus_req && (region == RG_DIST);

  // Slot sideband
  always_comb begin
    any_core_sel = |{cpuif_sel, tmr_sel, wdt_sel};
    any_sel      = any_core_sel || dist_sel;
    slot_we      = any_sel && bus_we;
    slot_wdata   = bus_wdata;
    slot_off     = any_sel ? local_off : '0;
    if (!any_core_sel)          slot_core = '0;
    else if (slot_idx == '0)    slot_core = bus_core;
    else                        slot_core = CID_W'(slot_idx - IDX_W'(1));
  end

  // Read data of the selected slot
  always_comb begin
    slot_rd = dist_sel ? dist_rdata : '0;
    for (int s = 0; s < NSLOT; s++) begin
      if (cpuif_sel[s]) slot_rd = slot_rd | cpuif_rdata[s*DATA_W +: DATA_W];
      if (tmr_sel[s])   slot_rd = slot_rd | tmr_rdata[s*DATA_W +: DATA_W];
      if (wdt_sel[s])   slot_rd = slot_rd | wdt_rdata[s*DATA_W +: DATA_W];
    end
    rd_mux = scu_acc ? scu_rd : slot_rd;
  end

  // Response next state
  always_comb begin
    rsp_en  = bus_req || ready_q;
    ready_d = bus_req;
    err_d   = bus_req && ((region == RG_NONE) || scu_bad);
    data_d  = (bus_req && !bus_we && !err_d) ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      err_q   <= 1'b0;
      data_q  <= '0;
    end else if (rsp_en) begin
      ready_q <= ready_d;
      err_q   <= err_d;
      data_q  <= data_d;
    end
  end

  assign bus_ready = ready_q;
  assign bus_err   = err_q;
  assign bus_rdata = data_q;

  // R11: a response follows every request, and only a request
  a_r11_ready_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_ready);
  a_r11_no_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req |=> !bus_ready);

  // R8: at most one slot strobe, none for unmapped space
  a_r8_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpuif_sel, tmr_sel, wdt_sel, dist_sel}));
  a_r8_unmapped_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (region == RG_NONE) |-> ({cpuif_sel, tmr_sel, wdt_sel, dist_sel} == '0));

  // R4: an error response never carries data
  a_r4_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0));

  // R10: alias slots carry the requester's core ID
  a_r10_alias_core: assert property (@(posedge clk) disable iff (!rst_n)
    (cpuif_sel[0] || tmr_sel[0] || wdt_sel[0]) |-> (slot_core == bus_core));

endmodule

// File: tb/cpw_front_bench.sv
module cpw_front_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RAND_CYCLES = 4000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req = 1'b0;
  logic         we = 1'b0;
  logic [12:0]  addr = '0;
  logic [31:0]  wdata = '0;
  logic [1:0]   core = '0;
  logic [159:0] cpuif_rd = '0;
  logic [159:0] tmr_rd = '0;
  logic [159:0] wdt_rd = '0;
  logic [31:0]  dist_rd = '0;
  logic [3:0]   tirq = '0;
  logic [3:0]   wirq = '0;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Instance with four cores
  logic [31:0]  a_rdata;  logic a_ready, a_err;
  logic [4:0]   a_csel, a_tsel, a_wsel; logic a_dsel, a_swe;
  logic [31:0]  a_swd;    logic [11:0] a_off; logic [1:0] a_core;
  logic [127:0] a_ppi;

  cpw_front #(.NUM_CORES(4)) u_cpw_front (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_core(core), .bus_rdata(a_rdata), .bus_ready(a_ready),
    .bus_err(a_err), .cpuif_sel(a_csel), .tmr_sel(a_tsel), .wdt_sel(a_wsel),
    .dist_sel(a_dsel), .slot_we(a_swe), .slot_wdata(a_swd), .slot_off(a_off),
    .slot_core(a_core), .cpuif_rdata(cpuif_rd), .tmr_rdata(tmr_rd),
    .wdt_rdata(wdt_rd), .dist_rdata(dist_rd), .tmr_irq(tirq), .wdt_irq(wirq),
    .ppi_irq(a_ppi)
  );

  // Instance with two cores
  logic [31:0]  b_rdata;  logic b_ready, b_err;
  logic [2:0]   b_csel, b_tsel, b_wsel; logic b_dsel, b_swe;
  logic [31:0]  b_swd;    logic [11:0] b_off; logic [1:0] b_core;
  logic [63:0]  b_ppi;

  cpw_front #(.NUM_CORES(2)) u_cpw_front_2c (
    .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_core(core), .bus_rdata(b_rdata), .bus_ready(b_ready),
    .bus_err(b_err), .cpuif_sel(b_csel), .tmr_sel(b_tsel), .wdt_sel(b_wsel),
    .dist_sel(b_dsel), .slot_we(b_swe), .slot_wdata(b_swd), .slot_off(b_off),
    .slot_core(b_core), .cpuif_rdata(cpuif_rd[95:0]), .tmr_rdata(tmr_rd[95:0]),
    .wdt_rdata(wdt_rd[95:0]), .dist_rdata(dist_rd), .tmr_irq(tirq[1:0]),
    .wdt_irq(wirq[1:0]), .ppi_irq(b_ppi)
  );

  task automatic check(input string tag, input int d, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s dut%0d actual=%h expected=%h", tag, d, act, exp);
    end
  endtask

  // kind: 0 scu, 1 cpu-interface, 2 timer, 3 watchdog, 4 distributor, 5 unmapped
  function automatic void decode(input int n, input int a, output int kind, output int idx);
    int pg, bo;
    pg = (a >> 8) & 15;
    bo = a & 255;
    kind = 5;
    idx = 0;
    if (a >= 4096) kind = 4;
    else if (pg == 0) kind = 0;
    else if (pg < 6) begin
      idx = pg - 1;
      if (idx <= n) kind = 1;
    end else begin
      idx = pg - 6;
      if (idx <= n) begin
        if (bo < 32) kind = 2;
        else if (bo < 64) kind = 3;
      end
    end
  endfunction

  function automatic logic [31:0] cfg_of(input int n);
    return 32'(((1 << n) - 1) << 4) | 32'(n - 1);
  endfunction

  // Reference model state, one entry per instance
  logic        m_ctrl [2];
  logic        e_ready[2];
  logic        e_err  [2];
  logic [31:0] e_data [2];

  always @(posedge clk) begin
    for (int d = 0; d < 2; d++) begin
      int n, kind, idx, off;
      n = (d == 0) ? 4 : 2;
      if (!rst_n) begin
        m_ctrl[d] = 1'b0; e_ready[d] = 1'b0; e_err[d] = 1'b0; e_data[d] = '0;
      end else begin
        decode(n, int'(addr), kind, idx);
        off = int'(addr) & 255;
        e_ready[d] = req;
        e_err[d]   = 1'b0;
        e_data[d]  = '0;
        if (req) begin
          if (kind == 5) e_err[d] = 1'b1;
          else if (kind == 0) begin
            if (we) begin
              if (off == 0) m_ctrl[d] = wdata[0];
              else if (off != 12) e_err[d] = 1'b1;
            end else begin
              if (off == 0) e_data[d] = {31'b0, m_ctrl[d]};
              else if (off == 4) e_data[d] = cfg_of(n);
              else if (off != 8 && off != 12) e_err[d] = 1'b1;
            end
          end else if (!we) begin
            case (kind)
              1: e_data[d] = cpuif_rd[idx*32 +: 32];
              2: e_data[d] = tmr_rd[idx*32 +: 32];
              3: e_data[d] = wdt_rd[idx*32 +: 32];
              default: e_data[d] = dist_rd;
            endcase
          end
        end
      end
    end

    #2;
    for (int d = 0; d < 2; d++) begin
      int n, kind, idx, a;
      logic [4:0] ec, et, ew; logic ed, ewe;
      logic [11:0] eo; logic [1:0] ecore; logic [127:0] eppi;
      n = (d == 0) ? 4 : 2;
      a = int'(addr);
      decode(n, a, kind, idx);
      ec = '0; et = '0; ew = '0; ed = 1'b0; eo = '0; ecore = '0;
      if (req) begin
        case (kind)
          1: begin ec = 5'(1 << idx); eo = 12'(a & 255); end
          2: begin et = 5'(1 << idx); eo = 12'(a & 31); end
          3: begin ew = 5'(1 << idx); eo = 12'(a & 31); end
          4: begin ed = 1'b1; eo = 12'(a & 4095); end
          default: ;
        endcase
        if (kind >= 1 && kind <= 3) ecore = (idx == 0) ? core : 2'(idx - 1);
      end
      ewe = req && we && kind >= 1 && kind <= 4;
      eppi = '0;
      for (int c = 0; c < n; c++) begin
        eppi[c*32 + 29] = tirq[c];
        eppi[c*32 + 30] = wirq[c];
      end
      if (d == 0) begin
        check("R11 ready", d, 128'(a_ready), 128'(e_ready[d]));
        check("R8 err", d, 128'(a_err), 128'(e_err[d]));
        check("R12 rdata", d, 128'(a_rdata), 128'(e_data[d]));
        check("R5 cpuif_sel", d, 128'(a_csel), 128'(ec));
        check("R6 tmr_sel", d, 128'(a_tsel), 128'(et));
        check("R6 wdt_sel", d, 128'(a_wsel), 128'(ew));
        check("R7 dist_sel", d, 128'(a_dsel), 128'(ed));
        check("R11 slot_we", d, 128'(a_swe), 128'(ewe));
        check("R11 slot_wdata", d, 128'(a_swd), 128'(wdata));
        check("R5 slot_off", d, 128'(a_off), 128'(eo));
        check("R10 slot_core", d, 128'(a_core), 128'(ecore));
        check("R9 ppi", d, a_ppi, eppi);
      end else begin
        check("R11 ready", d, 128'(b_ready), 128'(e_ready[d]));
        check("R8 err", d, 128'(b_err), 128'(e_err[d]));
        check("R12 rdata", d, 128'(b_rdata), 128'(e_data[d]));
        check("R5 cpuif_sel", d, 128'(b_csel), 128'(ec));
        check("R6 tmr_sel", d, 128'(b_tsel), 128'(et));
        check("R6 wdt_sel", d, 128'(b_wsel), 128'(ew));
        check("R7 dist_sel", d, 128'(b_dsel), 128'(ed));
        check("R11 slot_we", d, 128'(b_swe), 128'(ewe));
        check("R11 slot_wdata", d, 128'(b_swd), 128'(wdata));
        check("R5 slot_off", d, 128'(b_off), 128'(eo));
        check("R10 slot_core", d, 128'(b_core), 128'(ecore));
        check("R9 ppi", d, 128'(b_ppi), eppi);
      end
    end
  end

  // One access: drive at a falling edge, response visible at the next one
  task automatic access(input logic w, input int a, input logic [31:0] wd);
    @(negedge clk);
    req = 1'b1; we = w; addr = 13'(a); wdata = wd;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic fill_slots();
    for (int s = 0; s < 5; s++) begin
      cpuif_rd[s*32 +: 32] = $urandom;
      tmr_rd[s*32 +: 32]   = $urandom;
      wdt_rd[s*32 +: 32]   = $urandom;
    end
    dist_rd = $urandom;
  endtask

  initial begin
    fill_slots();
    repeat (3) @(negedge clk);
    check("R11 reset ready", 0, 128'(a_ready), 128'(0));
    check("R11 reset rdata", 0, 128'(a_rdata), 128'(0));
    rst_n = 1'b1;

    access(1'b0, 'h000, 0);
    check("R1 ctrl reset", 0, 128'(a_rdata), 128'(0));
    access(1'b1, 'h000, 32'hFFFF_FFFF);
    access(1'b0, 'h000, 0);
    check("R1 ctrl bit0 only", 0, 128'(a_rdata), 128'(1));
    access(1'b1, 'h000, 32'hFFFF_FFFE);
    access(1'b0, 'h000, 0);
    check("R1 ctrl cleared", 0, 128'(a_rdata), 128'(0));
    access(1'b1, 'h000, 32'h1);

    access(1'b0, 'h004, 0);
    check("R2 cfg 4 cores", 0, 128'(a_rdata), 128'(32'hF3));
    check("R2 cfg 2 cores", 1, 128'(b_rdata), 128'(32'h31));

    access(1'b0, 'h008, 0);
    check("R3 status zero", 0, 128'({a_err, a_rdata}), 128'(0));
    access(1'b0, 'h00C, 0);
    check("R3 inval read zero", 0, 128'({a_err, a_rdata}), 128'(0));
    access(1'b1, 'h00C, 32'h0);
    check("R3 inval write no err", 0, 128'(a_err), 128'(0));
    access(1'b0, 'h000, 0);
    check("R3 ctrl after inval", 0, 128'(a_rdata), 128'(1));

    access(1'b0, 'h010, 0);
    check("R4 bad read err", 0, 128'({a_err, a_rdata}), 128'({1'b1, 32'h0}));
    access(1'b1, 'h004, 32'h0);
    check("R4 write to cfg err", 0, 128'(a_err), 128'(1));
    @(negedge clk);
    check("R4 err one cycle", 0, 128'(a_err), 128'(0));
    access(1'b1, 'h014, 32'h0);
    access(1'b0, 'h000, 0);
    check("R4 ctrl kept", 0, 128'(a_rdata), 128'(1));

    access(1'b0, 'h400, 0);
    check("R8 slot3 beyond count", 1, 128'({b_err, b_rdata}), 128'({1'b1, 32'h0}));
    check("R5 slot3 present", 0, 128'({a_err, a_rdata}), 128'({1'b0, cpuif_rd[96 +: 32]}));
    access(1'b0, 'h640, 0);
    check("R8 timer page gap", 0, 128'(a_err), 128'(1));
    access(1'b0, 'h1ABC, 0);
    check("R7 dist read", 0, 128'(a_rdata), 128'(dist_rd));

    for (int i = 0; i < RAND_CYCLES; i++) begin
      int r;
      @(negedge clk);
      fill_slots();
      tirq = 4'($urandom); wirq = 4'($urandom);
      core = 2'($urandom);
      req = ($urandom % 10) < 7;
      we = $urandom % 2;
      wdata = $urandom;
      r = $urandom % 4;
      if (r == 0) addr = 13'($urandom % 20);
      else addr = 13'($urandom);
    end
    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (RAND_CYCLES + 2000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule